// File: doc/BRIEF.md
# Parallel quadratic-polynomial interleaver address generator

This block maps eight arbitrary symbol positions to their permuted positions under a quadratic permutation polynomial, all in the same cycle. It serves an iterative soft-output decoder that reads its inputs in order and scatters its results. In the interleaving half of an iteration, each result goes to the permuted position. In the other half, the result goes straight back to its own position, so the block returns each index unchanged.

Each permuted position is computed directly from its own index. No lane depends on the address of the previous index, so any eight positions can be mapped together, in any order. The index is reduced in two steps: the linear coefficient is added to the quadratic coefficient times the index, and that sum is reduced modulo the block length. The result is multiplied by the index and reduced again. Because of this nesting, no intermediate value is wider than twice the address width.

Each modulo is a chain of registered compare-and-subtract steps. A new batch of eight indices, with its own block length and coefficients, is accepted on every clock. The batch appears at the output a fixed number of cycles later.

Top module: `qpp_addr_gen`

## Requirements
- R1: With `half_sel` = 0, lane `l` of `addr` (bits `l*13+12 : l*13`) equals (`coef_lin`·x + `coef_quad`·x²) mod `blk_len`. Here x is lane `l` of `idx`, and the block length and coefficients are the ones presented with that batch.
- R2: With `half_sel` = 1, each lane of `addr` equals the same lane of `idx`.
- R3: Every address emitted with `out_valid` high is less than the `blk_len` of its batch.
- R4: `out_valid` rises exactly 30 cycles (2·13 + 4) after the clock edge that samples `in_valid` high. No pulse appears for a cycle in which `in_valid` was low.
- R5: A new batch is accepted on every clock, back to back. The eight lanes are independent, and the indices within a batch may come in any order.
- R6: Block lengths up to 6144 are handled, with x, `coef_lin` and `coef_quad` up to `blk_len`−1, without overflow.
- R7: A clock edge with `rst` high clears all work in flight. `out_valid` then stays low until a batch presented after reset has completed.
- R8: The block length and coefficients may change from one batch to the next. Each batch uses only the values sampled with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A batch is presented this cycle |
| half_sel | input | 1 | 0: permuted addresses, 1: indices returned unchanged |
| blk_len | input | 13 | Block length N, from 1 to 6144 |
| coef_lin | input | 13 | Linear coefficient, less than N |
| coef_quad | input | 13 | Quadratic coefficient, less than N |
| idx | input | 104 | Eight indices of 13 bits each, lane 0 in the low bits, each less than N |
| out_valid | output | 1 | A batch of addresses is on `addr` |
| addr | output | 104 | Eight addresses, same lane layout as `idx` |

## Verification
The assertions track `in_valid`, `half_sel`, `blk_len` and `idx` through a delay line of their own. On every cycle they check four things: the 30-cycle valid timing, the unchanged-index behaviour of the second half, the bound below the block length, and that index 0 always maps to address 0. None of these can show that a permuted address holds the right value. That needs the bench's arithmetic reference. The bench sweeps every coefficient pair and every index for block lengths 1 to 10 and covers the full-size block at its extremes. It also streams batches back to back and with gaps, with the parameters changing every cycle, and resets with data in flight.

// File: rtl/qpp_pkg.sv
package qpp_pkg;
  localparam int unsigned QPP_LANES = 8;
  localparam int unsigned QPP_NMAX  = 6144;

  function automatic int unsigned qpp_addr_bits(input int unsigned nmax);
    return $clog2(nmax + 1);
  endfunction

  function automatic int unsigned qpp_latency(input int unsigned aw);
    return 2 * aw + 4;
  endfunction
endpackage

// File: rtl/qpp_mod_reduce.sv
// Pipelined modulo by restoring subtraction. The input must be below
// m << STEPS. Stage s subtracts m << (STEPS-1-s) when it fits, so after
// stage s the value is below m << (STEPS-1-s). Each stage is one bit narrower.
module qpp_mod_reduce #(
  parameter int unsigned AW    = 13,
  parameter int unsigned STEPS = 13,
  parameter int unsigned PW    = 13,
  localparam int unsigned VW   = AW + STEPS
) (
  input  logic                  clk,
  input  logic [VW-1:0]         val_i,
  input  logic [PW-1:0]         pay_i,
  input  logic [STEPS*AW-1:0]   mod_i,   // modulus aligned with each stage
  output logic [AW-1:0]         rem_o,
  output logic [PW-1:0]         pay_o
);
  for (genvar s = 0; s < STEPS; s++) begin : g_st
    localparam int unsigned IW = AW + STEPS - s;
    localparam int unsigned OW = IW - 1;
    localparam int unsigned SH = STEPS - 1 - s;

    logic [IW-1:0] vin;
    logic [PW-1:0] pin;
    logic [IW-1:0] cand;
    logic [IW-1:0] diff;
    logic [OW-1:0] vq;
    logic [PW-1:0] pq;

    if (s == 0) begin : g_head
      assign vin = val_i;
      assign pin = pay_i;
    end else begin : g_link
      assign vin = g_st[s-1].vq;
      assign pin = g_st[s-1].pq;
    end

    assign cand = {{(IW-AW){1'b0}}, mod_i[s*AW +: AW]} << SH;
    assign diff = vin - cand;

    always_ff @(posedge clk) begin
      vq <= (vin >= cand) ? diff[OW-1:0] : vin[OW-1:0];
      pq <= pin;
    end
  end

  assign rem_o = g_st[STEPS-1].vq;
  assign pay_o = g_st[STEPS-1].pq;
endmodule

// File: rtl/qpp_lane.sv
// One address lane: ((b + a*x... ) nested form: r1 = (lin + quad*x) mod N,
// then addr = (r1 * x) mod N, or x itself in identity mode.
module qpp_lane #(
  parameter int unsigned AW = 13,
  localparam int unsigned VW = 2 * AW
) (
  input  logic               clk,
  input  logic [AW-1:0]      x_i,
  input  logic [AW-1:0]      lin_i,
  input  logic [AW-1:0]      quad_i,
  input  logic [AW*AW-1:0]   mod_a_i,
  input  logic [AW*AW-1:0]   mod_b_i,
  input  logic               ident_i,
  output logic [AW-1:0]      addr_o
);
  logic [VW-1:0] sum_q;
  logic [AW-1:0] x_a;
  logic [AW-1:0] r_a;
  logic [AW-1:0] x_b;
  logic [VW-1:0] prod_q;
  logic [AW-1:0] x_c;
  logic [AW-1:0] r_b;
  logic [AW-1:0] x_d;

  always_ff @(posedge clk) begin
    sum_q <= VW'(quad_i) * VW'(x_i) + VW'(lin_i);
    x_a   <= x_i;
  end

  qpp_mod_reduce #(.AW(AW), .STEPS(AW), .PW(AW)) u_red_a (
    .clk   (clk),
    .val_i (sum_q),
    .pay_i (x_a),
    .mod_i (mod_a_i),
    .rem_o (r_a),
    .pay_o (x_b)
  );

  always_ff @(posedge clk) begin
    prod_q <= VW'(r_a) * VW'(x_b);
    x_c    <= x_b;
  end

  qpp_mod_reduce #(.AW(AW), .STEPS(AW), .PW(AW)) u_red_b (
    .clk   (clk),
    .val_i (prod_q),
    .pay_i (x_c),
    .mod_i (mod_b_i),
    .rem_o (r_b),
    .pay_o (x_d)
  );

  always_ff @(posedge clk) begin
    addr_o <= ident_i ? x_d : r_b;
  end
endmodule

// File: rtl/qpp_addr_gen.sv
module qpp_addr_gen #(
  parameter int unsigned LANES = qpp_pkg::QPP_LANES,
  parameter int unsigned NMAX  = qpp_pkg::QPP_NMAX,
  localparam int unsigned AW   = qpp_pkg::qpp_addr_bits(NMAX),
  localparam int unsigned LAT  = qpp_pkg::qpp_latency(AW),
  localparam int unsigned ND   = 2 * AW + 2,   // modulus taps 0..2AW+1
  localparam int unsigned HD   = 2 * AW + 3    // mode taps 0..2AW+2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic                  half_sel,
  input  logic [AW-1:0]         blk_len,
  input  logic [AW-1:0]         coef_lin,
  input  logic [AW-1:0]         coef_quad,
  input  logic [LANES*AW-1:0]   idx,
  output logic                  out_valid,
  output logic [LANES*AW-1:0]   addr
);
  // Tap j of a delay line is loaded on clock edge j+1 after sampling.
  logic [AW-1:0]       n_dl [0:ND-1];
  logic                h_dl [0:HD-1];
  logic [LAT-1:0]      v_dl;
  logic [AW-1:0]       lin_q;
  logic [AW-1:0]       quad_q;
  logic [LANES*AW-1:0] x_q;
  logic [AW*AW-1:0]    mod_a;
  logic [AW*AW-1:0]    mod_b;

  always_ff @(posedge clk) begin
    n_dl[0] <= blk_len;
    for (int j = 1; j < ND; j++) n_dl[j] <= n_dl[j-1];
    h_dl[0] <= half_sel;
    for (int j = 1; j < HD; j++) h_dl[j] <= h_dl[j-1];
    lin_q  <= coef_lin;
    quad_q <= coef_quad;
    x_q    <= idx;
  end

  always_ff @(posedge clk) begin
    if (rst) v_dl <= '0;
    else     v_dl <= {v_dl[LAT-2:0], in_valid};
  end

  // First reduction stage s sees data loaded on edge s+2 (tap s+1);
  // second reduction stage s sees data loaded on edge AW+s+3 (tap AW+s+2).
  for (genvar s = 0; s < AW; s++) begin : g_tap
    assign mod_a[s*AW +: AW] = n_dl[1 + s];
    assign mod_b[s*AW +: AW] = n_dl[AW + 2 + s];
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    qpp_lane #(.AW(AW)) u_lane (
      .clk     (clk),
      .x_i     (x_q[l*AW +: AW]),
      .lin_i   (lin_q),
      .quad_i  (quad_q),
      .mod_a_i (mod_a),
      .mod_b_i (mod_b),
      .ident_i (h_dl[HD-1]),
      .addr_o  (addr[l*AW +: AW])
    );
  end

  assign out_valid = v_dl[LAT-1];
endmodule

// File: rtl/qpp_addr_gen_chk.sv
module qpp_addr_gen_chk #(
  parameter int unsigned LANES = 8,
  parameter int unsigned AW    = 13,
  parameter int unsigned LAT   = 30
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic                half_sel,
  input logic [AW-1:0]       blk_len,
  input logic [LANES*AW-1:0] idx,
  input logic                out_valid,
  input logic [LANES*AW-1:0] addr
);
  logic [LAT-1:0]      vp;
  logic                hp [0:LAT-1];
  logic [AW-1:0]       np [0:LAT-1];
  logic [LANES*AW-1:0] xp [0:LAT-1];

  always_ff @(posedge clk) begin
    if (rst) vp <= '0;
    else     vp <= {vp[LAT-2:0], in_valid};
    hp[0] <= half_sel;
    np[0] <= blk_len;
    xp[0] <= idx;
    for (int j = 1; j < LAT; j++) begin
      hp[j] <= hp[j-1];
      np[j] <= np[j-1];
      xp[j] <= xp[j-1];
    end
  end

  function automatic logic lanes_below(input logic [LANES*AW-1:0] a, input logic [AW-1:0] n);
    for (int l = 0; l < LANES; l++) if (a[l*AW +: AW] >= n) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic zero_maps_zero(input logic [LANES*AW-1:0] a, input logic [LANES*AW-1:0] x);
    for (int l = 0; l < LANES; l++)
      if (x[l*AW +: AW] == '0 && a[l*AW +: AW] != '0) return 1'b0;
    return 1'b1;
  endfunction

  AST_VALID_TIMING: assert property (@(posedge clk) disable iff (rst) out_valid == vp[LAT-1]); // R4
  AST_IDENTITY_HALF: assert property (@(posedge clk) disable iff (rst) (out_valid && hp[LAT-1]) |-> addr == xp[LAT-1]); // R2
  AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (rst) (out_valid && !hp[LAT-1]) |-> lanes_below(addr, np[LAT-1])); // R3
  AST_ZERO_INDEX: assert property (@(posedge clk) disable iff (rst) (out_valid && !hp[LAT-1]) |-> zero_maps_zero(addr, xp[LAT-1])); // R1
  AST_RESET_FLUSH: assert property (@(posedge clk) rst |=> !out_valid); // R7
endmodule

bind qpp_addr_gen qpp_addr_gen_chk #(.LANES(LANES), .AW(AW), .LAT(LAT)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .half_sel  (half_sel),
  .blk_len   (blk_len),
  .idx       (idx),
  .out_valid (out_valid),
  .addr      (addr)
);

// File: tb/qpp_addr_gen_tb.sv
module qpp_addr_gen_tb;
  localparam int LANES = 8;
  localparam int AW    = 13;
  localparam int LAT   = 2 * AW + 4;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                in_valid = 1'b0;
  logic                half_sel = 1'b0;
  logic [AW-1:0]       blk_len = '0;
  logic [AW-1:0]       coef_lin = '0;
  logic [AW-1:0]       coef_quad = '0;
  logic [LANES*AW-1:0] idx = '0;
  logic                out_valid;
  logic [LANES*AW-1:0] addr;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  int                  q_cyc [$];
  logic [LANES*AW-1:0] q_exp [$];
  string               q_tag [$];

  always #10 clk = ~clk;   // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  qpp_addr_gen u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .half_sel(half_sel),
    .blk_len(blk_len), .coef_lin(coef_lin), .coef_quad(coef_quad),
    .idx(idx), .out_valid(out_valid), .addr(addr)
  );

  task automatic note(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Drive one batch on the coming cycle and queue its reference result.
  task automatic send(input int n, input int f1, input int f2, input bit h,
                      input int xs [LANES], input string tag);
    logic [LANES*AW-1:0] e;
    @(negedge clk);
    in_valid  = 1'b1;
    half_sel  = h;
    blk_len   = AW'(n);
    coef_lin  = AW'(f1);
    coef_quad = AW'(f2);
    for (int l = 0; l < LANES; l++) begin
      longint unsigned x = longint'(xs[l]);
      longint unsigned r = (longint'(f1) * x + longint'(f2) * x * x) % longint'(n);
      idx[l*AW +: AW] = AW'(xs[l]);
      e[l*AW +: AW]   = h ? AW'(xs[l]) : AW'(r);
    end
    q_cyc.push_back(cyc + LAT);
    q_exp.push_back(e);
    q_tag.push_back(tag);
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // Scoreboard: outputs are sampled on the falling edge.
  always @(negedge clk) begin
    if (!rst) begin
      if (q_cyc.size() != 0 && q_cyc[0] == cyc) begin
        note(out_valid == 1'b1, "R4 valid timing", longint'(out_valid), 1);
        for (int l = 0; l < LANES; l++)
          note(addr[l*AW +: AW] == q_exp[0][l*AW +: AW], q_tag[0],
               longint'(addr[l*AW +: AW]), longint'(q_exp[0][l*AW +: AW]));
        void'(q_cyc.pop_front());
        void'(q_exp.pop_front());
        void'(q_tag.pop_front());
      end else if (out_valid) begin
        note(1'b0, "R4 unexpected valid", 1, 0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int xs [LANES];
    repeat (4) @(negedge clk);
    note(out_valid == 1'b0, "R7 reset state", longint'(out_valid), 0);
    @(negedge clk);
    rst = 1'b0;
    idle(2);

    // R1 R5 R8: every coefficient pair and index for N = 1..10, streamed
    // back to back with parameters changing every cycle.
    for (int n = 1; n <= 10; n++)
      for (int a = 0; a < n; a++)
        for (int b = 0; b < n; b++)
          for (int k = 0; k < n; k++) begin
            for (int l = 0; l < LANES; l++) xs[l] = (k + 3 * l) % n;
            send(n, a, b, 1'b0, xs, "R1 R8 small sweep");
          end

    // R1 R5: N = 40, all indices in descending order across lanes.
    for (int k = 0; k < 5; k++) begin
      for (int l = 0; l < LANES; l++) xs[l] = 39 - (k * LANES + l);
      send(40, 3, 10, 1'b0, xs, "R1 R5 descending");
    end
    // R2: identity half, mixed with interleaved batches.
    for (int k = 0; k < 5; k++) begin
      for (int l = 0; l < LANES; l++) xs[l] = (k * LANES + l * 7) % 40;
      send(40, 3, 10, 1'b1, xs, "R2 identity half");
      send(40, 3, 10, 1'b0, xs, "R1 after identity");
    end
    idle(3);

    // R6: largest block length, extremes of index and coefficients.
    for (int k = 0; k < 20; k++) begin
      for (int l = 0; l < LANES; l++) xs[l] = (6143 - k * 307 - l * 761 + 6144 * 4) % 6144;
      send(6144, 263, 480, 1'b0, xs, "R6 full length");
    end
    for (int l = 0; l < LANES; l++) xs[l] = 6143 - l;
    send(6144, 6143, 6143, 1'b0, xs, "R6 max operands");
    send(6144, 6143, 6143, 1'b1, xs, "R2 R6 identity at max");
    send(6143, 6142, 6141, 1'b0, xs, "R6 odd length");

    // R4: isolated batches with gaps.
    for (int k = 0; k < 4; k++) begin
      for (int l = 0; l < LANES; l++) xs[l] = (k * 11 + l * 5) % 256;
      send(256, 15, 32, 1'b0, xs, "R4 gapped batch");
      idle(k + 1);
    end
    idle(LAT + 4);
    note(q_cyc.size() == 0, "R4 all batches returned", longint'(q_cyc.size()), 0);

    // R7: reset with batches in flight, nothing may emerge.
    for (int k = 0; k < 3; k++) begin
      for (int l = 0; l < LANES; l++) xs[l] = l + k;
      send(100, 7, 20, 1'b0, xs, "R7 flushed");
    end
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    q_cyc.delete();
    q_exp.delete();
    q_tag.delete();
    @(negedge clk);
    note(out_valid == 1'b0, "R7 flush on reset", longint'(out_valid), 0);
    @(negedge clk);
    rst = 1'b0;
    idle(LAT + 4);
    note(out_valid == 1'b0, "R7 stays idle", longint'(out_valid), 0);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule